// File: doc/BRIEF.md
# SECDED 72/64 ECC Codec

This block is a purely combinational codec that protects a 64-bit data word with an 8-bit check byte. Together they form a 72-bit codeword that corrects any single flipped bit and detects every double flip. The encoder path turns a data word into its check byte. The decoder path takes a stored codeword and recomputes the check byte from the data half. It XORs that result with the stored check half to form an 8-bit syndrome.

Each data bit owns a fixed odd-weight parity-check column. Because of that, the syndrome on its own decides the outcome:

- A zero syndrome means the word is clean.
- A syndrome equal to one data column names the bad data bit, and that bit is flipped back.
- A syndrome with a single bit set names a bad check bit. The data half is already correct in that case.
- Any other syndrome is reported as uncorrectable, and the data passes through untouched.

A memory controller places the encoder on its write path and the decoder on its read path. The decoder's correctable and uncorrectable flags feed the controller's error reporting. The syndrome is brought out so that the failing bit can be logged.

Top module: `secded_codec`

## Requirements
- R1: `encChkOut` bit j is the XOR of every `encDataIn` bit i whose column (see R2) has bit j set; an all-zero word encodes to 8'h00.
- R2: Data bit i has this column (hex), for i = 0 upward: f4 f1 ec ea e9 e6 e5 e3 dc da d9 d6 d5 d3 ce cb b5 b0 ad ab a8 a7 a4 a2 9d 9b 98 97 94 92 8f 8a 75 70 6d 6b 68 67 64 62 5e 5b 58 57 54 52 4f 4a 34 31 2c 2a 29 26 25 23 1c 1a 19 16 15 13 0e 0b; a flip of only data bit i gives exactly that column as syndrome.
- R3: `decSyndrome` equals the check byte recomputed from `decDataIn` (per R1) XOR `decChkIn`.
- R4: A zero syndrome raises neither flag, and `decDataOut` equals `decDataIn`.
- R5: A syndrome equal to the column of data bit i raises `decCorrectable` only, and `decDataOut` is `decDataIn` with bit i inverted.
- R6: A flip of only check bit i gives syndrome 1<<i and raises `decCorrectable` only, with `decDataOut` equal to `decDataIn`.
- R7: Any nonzero even-weight syndrome (every double flip) raises `decUncorrectable` only, with `decDataOut` equal to `decDataIn`.
- R8: Syndrome 8'h03, the result of flipping check bits 0 and 1, is uncorrectable.
- R9: An odd-weight syndrome that matches no column and has more than one bit set (for example 8'h07 or 8'h7f) is uncorrectable, with data passed unchanged.
- R10: `decCorrectable` and `decUncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| encDataIn | input | 64 | Data word to be encoded |
| encChkOut | output | 8 | Check byte for `encDataIn` |
| decDataIn | input | 64 | Data half of the received codeword |
| decChkIn | input | 8 | Check half of the received codeword |
| decDataOut | output | 64 | Data after correction |
| decSyndrome | output | 8 | Recomputed check byte XOR received check byte |
| decCorrectable | output | 1 | A single data or check bit was in error (corrected) |
| decUncorrectable | output | 1 | Error that cannot be corrected |

## Verification
The bench drives several kinds of codeword:

- **Clean codewords**, with random data and with the all-zero and all-ones words, built from a behavioural encoder. These prove the encoder and the pass-through path.
- **A walk of a single flip over all 64 data positions.** This separates a correct column table from one with a swapped or mistyped entry, because every column must both appear as the syndrome and steer the flip to the right bit.
- **Single check-bit flips.** These separate check-bit errors from data errors: the flag is raised and the data stays untouched.
- **Random double flips, the 0x03 pattern and odd-weight unmatched syndromes such as 0x07 and 0x7f.** These separate detection from miscorrection.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef struct packed {
    logic [DATA_W-1:0] dataFlip;  // one-hot (or zero) bit to invert
    logic              corrOk;    // single error located
    logic              uncorr;    // error not correctable
  } ctlStrobe_t;

  // Parity-check column of data bit idx; every column has odd weight.
  function automatic logic [CHK_W-1:0] colOf(input int unsigned idx);
    logic [CHK_W-1:0] c;
    case (idx)
      0: c = 8'hf4;  1: c = 8'hf1;  2: c = 8'hec;  3: c = 8'hea;
      4: c = 8'he9;  5: c = 8'he6;  6: c = 8'he5;  7: c = 8'he3;
      8: c = 8'hdc;  9: c = 8'hda; 10: c = 8'hd9; 11: c = 8'hd6;
     12: c = 8'hd5; 13: c = 8'hd3; 14: c = 8'hce; 15: c = 8'hcb;
     16: c = 8'hb5; 17: c = 8'hb0; 18: c = 8'had; 19: c = 8'hab;
     20: c = 8'ha8; 21: c = 8'ha7; 22: c = 8'ha4; 23: c = 8'ha2;
     24: c = 8'h9d; 25: c = 8'h9b; 26: c = 8'h98; 27: c = 8'h97;
     28: c = 8'h94; 29: c = 8'h92; 30: c = 8'h8f; 31: c = 8'h8a;
     32: c = 8'h75; 33: c = 8'h70; 34: c = 8'h6d; 35: c = 8'h6b;
     36: c = 8'h68; 37: c = 8'h67; 38: c = 8'h64; 39: c = 8'h62;
     40: c = 8'h5e; 41: c = 8'h5b; 42: c = 8'h58; 43: c = 8'h57;
     44: c = 8'h54; 45: c = 8'h52; 46: c = 8'h4f; 47: c = 8'h4a;
     48: c = 8'h34; 49: c = 8'h31; 50: c = 8'h2c; 51: c = 8'h2a;
     52: c = 8'h29; 53: c = 8'h26; 54: c = 8'h25; 55: c = 8'h23;
     56: c = 8'h1c; 57: c = 8'h1a; 58: c = 8'h19; 59: c = 8'h16;
     60: c = 8'h15; 61: c = 8'h13; 62: c = 8'h0e; 63: c = 8'h0b;
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/secded_parity.sv
module secded_parity
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] dataIn,
  output logic [CW-1:0] parOut
);
  for (genvar j = 0; j < CW; j++) begin : g_row
    always_comb begin
      logic acc;
      logic [CHK_W-1:0] col;
      acc = 1'b0;
      for (int i = 0; i < DW; i++) begin
        col = colOf(i);
        if (col[j]) acc = acc ^ dataIn[i];
      end
      parOut[j] = acc;
    end
  end
endmodule

// File: rtl/secded_classify.sv
module secded_classify
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [CW-1:0] syndrome,
  output ctlStrobe_t    strobe
);
  logic [DW-1:0] colHit;
  logic          chkHit;
  logic          anyHit;

  for (genvar i = 0; i < DW; i++) begin : g_col
    assign colHit[i] = (syndrome == colOf(i));
  end

  assign chkHit = (syndrome != '0) && ((syndrome & (syndrome - 1'b1)) == '0);
  assign anyHit = (|colHit) | chkHit;

  always_comb begin
    strobe.dataFlip = colHit;
    strobe.corrOk   = anyHit;
    strobe.uncorr   = (syndrome != '0) && !anyHit;
  end
endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] dataIn,
  input  logic [CW-1:0] chkIn,
  input  ctlStrobe_t    strobe,
  output logic [CW-1:0] syndrome,
  output logic [DW-1:0] dataOut
);
  logic [CW-1:0] recomputed;
  logic          flipEn;

  secded_parity #(.DW(DW), .CW(CW)) u_decPar (
    .dataIn (dataIn),
    .parOut (recomputed)
  );

  assign syndrome = recomputed ^ chkIn;
  assign flipEn   = strobe.corrOk & ~strobe.uncorr;
  assign dataOut  = dataIn ^ (strobe.dataFlip & {DW{flipEn}});
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] encDataIn,
  output logic [CW-1:0] encChkOut,
  input  logic [DW-1:0] decDataIn,
  input  logic [CW-1:0] decChkIn,
  output logic [DW-1:0] decDataOut,
  output logic [CW-1:0] decSyndrome,
  output logic          decCorrectable,
  output logic          decUncorrectable
);
  ctlStrobe_t strobe;

  secded_parity #(.DW(DW), .CW(CW)) u_encPar (
    .dataIn (encDataIn),
    .parOut (encChkOut)
  );

  secded_datapath #(.DW(DW), .CW(CW)) u_dp (
    .dataIn   (decDataIn),
    .chkIn    (decChkIn),
    .strobe   (strobe),
    .syndrome (decSyndrome),
    .dataOut  (decDataOut)
  );

  secded_classify #(.DW(DW), .CW(CW)) u_ctl (
    .syndrome (decSyndrome),
    .strobe   (strobe)
  );

  assign decCorrectable   = strobe.corrOk;
  assign decUncorrectable = strobe.uncorr;
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
  import secded_pkg::*;
(
  input logic [DATA_W-1:0] decDataIn,
  input logic [DATA_W-1:0] decDataOut,
  input logic [CHK_W-1:0]  decSyndrome,
  input logic              decCorrectable,
  input logic              decUncorrectable
);
  logic known;
  assign known = !$isunknown({decDataIn, decDataOut, decSyndrome,
                              decCorrectable, decUncorrectable});

  always_comb begin
    if (known) begin
      a_r10_flags_exclusive: assert (!(decCorrectable && decUncorrectable));
      if (decSyndrome == '0) begin
        a_r4_clean_passthru: assert (!decCorrectable && !decUncorrectable
                                     && decDataOut == decDataIn);
      end
      if (decUncorrectable) begin
        a_r7_uncorr_no_change: assert (decDataOut == decDataIn);
      end
      if (decCorrectable) begin
        a_r5_at_most_one_flip: assert ($countones(decDataOut ^ decDataIn) <= 1);
      end
      if ($onehot(decSyndrome)) begin
        a_r6_chk_err_data_kept: assert (decCorrectable && decDataOut == decDataIn);
      end
      if (decSyndrome != '0 && $countones(decSyndrome) % 2 == 0) begin
        a_r7_even_is_uncorr: assert (decUncorrectable);
      end
    end
  end
endmodule

bind secded_codec secded_codec_chk u_chk (
  .decDataIn        (decDataIn),
  .decDataOut       (decDataOut),
  .decSyndrome      (decSyndrome),
  .decCorrectable   (decCorrectable),
  .decUncorrectable (decUncorrectable)
);

// File: tb/secded_codec_tb.sv
module secded_codec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [63:0] encDataIn = '0;
  logic [7:0]  encChkOut;
  logic [63:0] decDataIn = '0;
  logic [7:0]  decChkIn = '0;
  logic [63:0] decDataOut;
  logic [7:0]  decSyndrome;
  logic        decCorrectable, decUncorrectable;

  secded_codec u_dut (
    .encDataIn(encDataIn), .encChkOut(encChkOut),
    .decDataIn(decDataIn), .decChkIn(decChkIn),
    .decDataOut(decDataOut), .decSyndrome(decSyndrome),
    .decCorrectable(decCorrectable), .decUncorrectable(decUncorrectable)
  );

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  byte unsigned colTab [64] = '{
    8'hf4,8'hf1,8'hec,8'hea,8'he9,8'he6,8'he5,8'he3,
    8'hdc,8'hda,8'hd9,8'hd6,8'hd5,8'hd3,8'hce,8'hcb,
    8'hb5,8'hb0,8'had,8'hab,8'ha8,8'ha7,8'ha4,8'ha2,
    8'h9d,8'h9b,8'h98,8'h97,8'h94,8'h92,8'h8f,8'h8a,
    8'h75,8'h70,8'h6d,8'h6b,8'h68,8'h67,8'h64,8'h62,
    8'h5e,8'h5b,8'h58,8'h57,8'h54,8'h52,8'h4f,8'h4a,
    8'h34,8'h31,8'h2c,8'h2a,8'h29,8'h26,8'h25,8'h23,
    8'h1c,8'h1a,8'h19,8'h16,8'h15,8'h13,8'h0e,8'h0b};

  function automatic logic [7:0] refEnc(logic [63:0] d);
    logic [7:0] p = '0;
    for (int i = 0; i < 64; i++) if (d[i]) p ^= colTab[i];
    return p;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives data d, with flip mask (bits 63:0 data, 71:64 check) on the decoder.
  task automatic runCase(logic [63:0] d, logic [71:0] flip, string req);
    logic [7:0]  goodChk, cIn, expSyn;
    logic [63:0] dIn, expData;
    logic        expCe, expUe;
    int          hit;
    @(negedge clk);
    goodChk   = refEnc(d);
    dIn       = d ^ flip[63:0];
    cIn       = goodChk ^ flip[71:64];
    encDataIn = d;
    decDataIn = dIn;
    decChkIn  = cIn;
    expSyn  = refEnc(dIn) ^ cIn;
    expData = dIn;
    expCe = 0; expUe = 0; hit = -1;
    if (expSyn != 0) begin
      for (int i = 0; i < 64; i++) if (colTab[i] == expSyn) hit = i;
      if (hit >= 0) begin expData[hit] = ~expData[hit]; expCe = 1; end
      else if ($countones(expSyn) == 1) expCe = 1;
      else expUe = 1;
    end
    @(posedge clk); #2;
    check("R1 encChkOut", {56'd0, encChkOut}, {56'd0, goodChk});
    check("R3 decSyndrome", {56'd0, decSyndrome}, {56'd0, expSyn});
    check({req, " decDataOut"}, decDataOut, expData);
    check({req, " flags"}, {62'd0, decCorrectable, decUncorrectable}, {62'd0, expCe, expUe});
    check("R10 flags exclusive", {63'd0, decCorrectable & decUncorrectable}, 64'd0);
  endtask

  initial begin
    logic [63:0] d;
    logic [71:0] f;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: zero word, clean (R1 zero encode, R4)
    #2;
    check("R1 reset encChkOut", {56'd0, encChkOut}, 64'd0);
    check("R4 reset flags", {62'd0, decCorrectable, decUncorrectable}, 64'd0);
    runCase(64'd0, 72'd0, "R4 zero word");
    runCase('1, 72'd0, "R4 all ones");
    for (int k = 0; k < 40; k++) runCase({$urandom, $urandom}, 72'd0, "R4 clean random");
    // R2/R5: single data flip walk
    for (int i = 0; i < 64; i++) begin
      d = {$urandom, $urandom};
      f = 72'd1 << i;
      runCase(d, f, "R5 single data flip");
      check("R2 column syndrome", {56'd0, decSyndrome}, {56'd0, colTab[i]});
    end
    // R6: single check flip
    for (int i = 0; i < 8; i++) begin
      runCase({$urandom, $urandom}, 72'd1 << (64 + i), "R6 check flip");
      check("R6 one-hot syndrome", {56'd0, decSyndrome}, 64'd1 << i);
    end
    // R7: random double flips
    for (int k = 0; k < 60; k++) begin
      int a, b;
      a = $urandom_range(71, 0);
      b = (a + 1 + $urandom_range(70, 0)) % 72;
      f = (72'd1 << a) | (72'd1 << b);
      runCase({$urandom, $urandom}, f, "R7 double flip");
      check("R7 uncorrectable", {63'd0, decUncorrectable}, 64'd1);
    end
    // R8: syndrome 0x03
    runCase({$urandom, $urandom}, {8'h03, 64'd0}, "R8 synd 03");
    check("R8 uncorrectable", {63'd0, decUncorrectable}, 64'd1);
    // R9: odd-weight unmatched syndromes
    runCase({$urandom, $urandom}, {8'h07, 64'd0}, "R9 synd 07");
    check("R9 uncorrectable 07", {63'd0, decUncorrectable}, 64'd1);
    runCase({$urandom, $urandom}, {8'h7f, 64'd0}, "R9 synd 7f");
    check("R9 uncorrectable 7f", {63'd0, decUncorrectable}, 64'd1);
    for (int k = 0; k < 30; k++) begin
      f = '0;
      for (int m = 0; m < 3; m++) f[$urandom_range(71, 0)] = 1'b1;
      runCase({$urandom, $urandom}, f, "R9 multi flip");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule